// File: doc/BRIEF.md
# Cache Range Clean/Invalidate Walker

This block carries out a maintenance operation over a byte range of a set-associative cache. A request gives a start address, a byte count and two independent flags: one asks for dirty lines to be cleaned, the other asks for lines to be invalidated. The block widens the range outward so that it covers whole lines. It then visits each line in ascending order. For each line it spends one cycle on a tag lookup and one cycle on a possible tag update.

A line that misses is left alone. On a hit, the clean flag turns a dirty line clean. Each such change raises a writeback pulse and advances a writeback counter. The invalidate flag clears the valid bit. When both flags are set, the writeback is counted before the line is dropped. No line data is moved; the pulse only tells a data path that a writeback is due.

When the local walk ends, the unchanged request is offered to the next cache level on a valid/ready port. The done pulse follows the handshake on that port. When the block is built without a next level, done follows the last line update directly.

Top module: `cmo_range_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `done`, `lk_valid`, `upd_en`, `wb_pulse` and `nl_valid` are 0, and `wb_count` is 0.
- R2: The first line looked up is the request address with its low log2(LINE_BYTES) bits cleared. Each later lookup address is exactly LINE_BYTES above the previous one.
- R3: The walk ends at (addr + bytes + LINE_BYTES - 1) rounded down to a multiple of LINE_BYTES. The number of lookups equals (end - first) / LINE_BYTES. An aligned address with a byte count of 0 gives no lookup at all.
- R4: Every line costs two cycles. The first is a lookup cycle with `lk_valid` high. The second is an update cycle with `lk_valid` low.
- R5: A lookup that misses writes nothing to the tag store. A hit on a clean line under a clean-only request also writes nothing.
- R6: On a hit of a dirty line with clean requested, the update writes valid unchanged and dirty 0. `wb_pulse` is 1 in that update cycle, and `wb_count` rises by one.
- R7: On a hit with invalidate requested, the update writes valid 0 and dirty 0. With both flags set, a dirty line still raises `wb_pulse` and counts a writeback.
- R8: With a next level present (HAS_NEXT=1), `nl_valid` rises in the cycle after the last update. It carries the original address, byte count and flags, and stays high until `nl_ready`. `done` is high for one cycle, the cycle after that handshake. For N lines and a ready that comes D cycles late, `done` is high 2N+1+D cycles after the accepting edge.
- R9: With HAS_NEXT=0, `nl_valid` stays 0. `done` is high for the single cycle after the last update, that is 2N cycles after the accepting edge.
- R10: `req_ready` is 0 from the accepting edge until `done` is high. A request offered in that window is ignored and does not disturb the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request may be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_bytes | input | LEN_W | Byte count of the range |
| req_clean | input | 1 | Clean dirty lines |
| req_inval | input | 1 | Invalidate hit lines |
| lk_valid | output | 1 | Lookup cycle |
| lk_addr | output | ADDR_W | Line-aligned lookup address |
| lk_hit | input | 1 | Tag store: line present |
| lk_way | input | WAY_W | Tag store: hitting way |
| lk_dirty | input | 1 | Tag store: hitting line is dirty |
| upd_en | output | 1 | Write the tag state of one line |
| upd_set | output | SET_W | Set of the line written |
| upd_way | output | WAY_W | Way of the line written |
| upd_valid | output | 1 | New valid bit |
| upd_dirty | output | 1 | New dirty bit |
| wb_pulse | output | 1 | A dirty line was cleaned this cycle |
| wb_count | output | WB_W | Writebacks counted since reset (wraps) |
| nl_valid | output | 1 | Forwarded request to next level |
| nl_ready | input | 1 | Next level accepts |
| nl_addr | output | ADDR_W | Forwarded start address |
| nl_bytes | output | LEN_W | Forwarded byte count |
| nl_clean | output | 1 | Forwarded clean flag |
| nl_inval | output | 1 | Forwarded invalidate flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with 8-bit addresses, a 6-bit byte count, 8-byte lines, 4 sets and 2 ways. It builds two instances: one with a next level and one without. With this small setup, a sweep over every start offset in three lines and every byte count from 0 to 19 covers each rounding case: aligned and unaligned starts, empty ranges, one-byte ranges and ranges that end exactly on a boundary. The sweep runs all four flag combinations against a tag store refilled before each request. Requests near the top of the address space push the end address past the 8-bit range. Next-level ready delays of 0 to 2 cycles test the done timing.

// File: rtl/cmo_walk_pkg.sv
// Shared types for the cache range walker.
// Assumes nothing beyond standard SystemVerilog.
package cmo_walk_pkg;

    // Walk phases: idle, tag lookup, tag update
    typedef enum logic [1:0] {
        WK_IDLE   = 2'd0,
        WK_LOOKUP = 2'd1,
        WK_UPDATE = 2'd2
    } walk_phase_e;

    // Action decided for one visited line
    typedef struct packed {
        logic write;     // tag store must be written
        logic valid;     // new valid bit
        logic dirty;     // new dirty bit
        logic wb;        // a dirty line became clean
    } line_act_t;

endpackage

// File: rtl/cmo_range_calc.sv
// Range rounding: turns a byte range into a half-open range of line addresses.
// Assumes LINE_BYTES is a power of two. Results are ADDR_W+2 bits wide,
// so the end address never wraps.
module cmo_range_calc #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    localparam int PTR_W     = ADDR_W + 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  bytes_n,
    output logic [PTR_W-1:0]  first_line,
    output logic [PTR_W-1:0]  end_line
);
    localparam logic [PTR_W-1:0] OFF_MASK = PTR_W'(LINE_BYTES - 1);

    logic [PTR_W-1:0] span_sum;

    // Round the start down and the end up to line boundaries
    always_comb begin
        span_sum   = PTR_W'(addr) + PTR_W'(bytes_n) + OFF_MASK;
        first_line = PTR_W'(addr) & ~OFF_MASK;
        end_line   = span_sum & ~OFF_MASK;
    end

endmodule

// File: rtl/cmo_line_policy.sv
// Per-line maintenance policy. Given the lookup result and the request
// flags, it decides the new tag state and whether a writeback is due.
// The clean action is taken first: a dirty line that is also invalidated
// still counts a writeback.
module cmo_line_policy
    import cmo_walk_pkg::*;
(
    input  logic      hit,
    input  logic      dirty,
    input  logic      do_clean,
    input  logic      do_inval,
    output line_act_t act
);
    // Combine clean and invalidate for a single line
    always_comb begin
        act.wb    = hit & do_clean & dirty;
        act.write = hit & ((do_clean & dirty) | do_inval);
        act.valid = ~do_inval;
        act.dirty = dirty & ~do_clean & ~do_inval;
    end

endmodule

// File: rtl/cmo_walk_ctrl.sv
// Walk sequencer. It latches an accepted request and visits each line
// from the first line up to the end line. Each line takes one lookup cycle
// and then one update cycle. It signals walk_end in the cycle that
// finishes the walk; for an empty range, that is the accepting cycle.
// Assumes the external tag store answers a lookup in the same cycle.
module cmo_walk_ctrl
    import cmo_walk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    localparam int PTR_W     = ADDR_W + 2,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  bytes_n,
    input  logic              do_clean,
    input  logic              do_inval,
    input  logic [PTR_W-1:0]  first_line,
    input  logic [PTR_W-1:0]  end_line,
    input  logic              lk_hit,
    input  logic [WAY_W-1:0]  lk_way,
    input  logic              lk_dirty,
    output logic              idle,
    output logic              lk_valid,
    output logic [ADDR_W-1:0] lk_addr,
    output logic              upd_en,
    output logic [SET_W-1:0]  upd_set,
    output logic [WAY_W-1:0]  upd_way,
    output logic              upd_valid,
    output logic              upd_dirty,
    output logic              wb_pulse,
    output logic              walk_end,
    output logic [ADDR_W-1:0] org_addr,
    output logic [LEN_W-1:0]  org_bytes,
    output logic              org_clean,
    output logic              org_inval
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(LINE_BYTES);

    walk_phase_e      phase;
    logic [PTR_W-1:0] cur_line;
    logic [PTR_W-1:0] stop_line;
    logic [PTR_W-1:0] next_line;
    logic             hit_q;
    logic [WAY_W-1:0] way_q;
    logic             dirty_q;
    logic             more_lines;
    line_act_t        act;

    // Address of the line after the current one, and whether it is in range
    always_comb begin
        next_line  = cur_line + STEP;
        more_lines = (next_line < stop_line);
    end

    // Decide the tag update from the captured lookup result
    cmo_line_policy u_policy (
        .hit      (hit_q),
        .dirty    (dirty_q),
        .do_clean (org_clean),
        .do_inval (org_inval),
        .act      (act)
    );

    // Phase sequencing, request capture and lookup result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= WK_IDLE;
            cur_line  <= '0;
            stop_line <= '0;
            hit_q     <= 1'b0;
            way_q     <= '0;
            dirty_q   <= 1'b0;
            org_addr  <= '0;
            org_bytes <= '0;
            org_clean <= 1'b0;
            org_inval <= 1'b0;
        end else begin
            case (phase)
                WK_IDLE: begin
                    if (start) begin
                        org_addr  <= addr;
                        org_bytes <= bytes_n;
                        org_clean <= do_clean;
                        org_inval <= do_inval;
                        cur_line  <= first_line;
                        stop_line <= end_line;
                        phase     <= (first_line < end_line) ? WK_LOOKUP : WK_IDLE;
                    end
                end
                WK_LOOKUP: begin
                    hit_q   <= lk_hit;
                    way_q   <= lk_way;
                    dirty_q <= lk_dirty;
                    phase   <= WK_UPDATE;
                end
                WK_UPDATE: begin
                    cur_line <= next_line;
                    phase    <= more_lines ? WK_LOOKUP : WK_IDLE;
                end
                default: phase <= WK_IDLE;
            endcase
        end
    end

    // Drive the lookup and update ports and the end-of-walk strobe
    always_comb begin
        idle      = (phase == WK_IDLE);
        lk_valid  = (phase == WK_LOOKUP);
        lk_addr   = cur_line[ADDR_W-1:0];
        upd_en    = (phase == WK_UPDATE) & act.write;
        upd_set   = cur_line[OFF_W +: SET_W];
        upd_way   = way_q;
        upd_valid = act.valid;
        upd_dirty = act.dirty;
        wb_pulse  = (phase == WK_UPDATE) & act.wb;
        walk_end  = ((phase == WK_IDLE) & start & ~(first_line < end_line)) |
                    ((phase == WK_UPDATE) & ~more_lines);
    end

    // R4: a lookup cycle is always followed by a cycle without lookup
    a_r4_lookup_then_update: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> !lk_valid);

    // R2: consecutive lookups of one walk are exactly one line apart
    a_r2_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(lk_valid, 2)) |->
            (lk_addr == $past(lk_addr, 2) + ADDR_W'(LINE_BYTES)));

    // R3: no lookup at or beyond the end line
    a_r3_inside_range: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (cur_line < stop_line));

    // R5: a tag write only follows a lookup that hit
    a_r5_write_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> ($past(lk_valid) && $past(lk_hit)));

    // R6: a writeback pulse always comes with a write that clears dirty
    a_r6_wb_clears_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        wb_pulse |-> (upd_en && !upd_dirty));

endmodule

// File: rtl/cmo_fwd_stage.sv
// Completion stage. With a next level, it offers the finished request on
// a valid/ready port and raises done after the handshake. Without one, it
// raises done in the cycle after the walk ends. The busy output covers
// the time from the end of the walk until done.
module cmo_fwd_stage #(
    parameter bit HAS_NEXT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic walk_end,
    input  logic nl_ready,
    output logic nl_valid,
    output logic done,
    output logic busy
);
    generate
        if (HAS_NEXT) begin : g_next
            logic pend_q;
            logic done_q;

            // Hold the forwarded request until the next level takes it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                    done_q <= 1'b0;
                end else begin
                    done_q <= pend_q & nl_ready;
                    if (walk_end)
                        pend_q <= 1'b1;
                    else if (nl_ready)
                        pend_q <= 1'b0;
                end
            end

            assign nl_valid = pend_q;
            assign done     = done_q;
            assign busy     = pend_q;

            // R8: the offer stays up until it is accepted
            a_r8_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
                (nl_valid && !nl_ready) |=> nl_valid);

            // R8: done only follows a completed handshake
            a_r8_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> $past(nl_valid && nl_ready));
        end else begin : g_leaf
            logic done_q;

            // Signal completion right after the walk
            always_ff @(posedge clk) begin
                if (!rst_n) done_q <= 1'b0;
                else        done_q <= walk_end;
            end

            assign nl_valid = 1'b0;
            assign done     = done_q;
            assign busy     = 1'b0;

            // R9: done follows the end of the walk by one cycle
            a_r9_done_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> $past(walk_end));
        end
    endgenerate

endmodule

// File: rtl/cmo_range_walker.sv
// Top of the cache range clean/invalidate walker. It takes one request at
// a time, walks the covered lines through the external tag store, counts
// the writebacks and then completes through the forwarding stage.
// Assumes a lookup answered in the cycle it is issued, a tag store that
// takes one update per cycle, and power-of-two line size, sets and ways.
module cmo_range_walker #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    parameter int WB_W       = 32,
    parameter bit HAS_NEXT   = 1'b1,
    localparam int PTR_W     = ADDR_W + 2,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_bytes,
    input  logic              req_clean,
    input  logic              req_inval,
    output logic              lk_valid,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_hit,
    input  logic [WAY_W-1:0]  lk_way,
    input  logic              lk_dirty,
    output logic              upd_en,
    output logic [SET_W-1:0]  upd_set,
    output logic [WAY_W-1:0]  upd_way,
    output logic              upd_valid,
    output logic              upd_dirty,
    output logic              wb_pulse,
    output logic [WB_W-1:0]   wb_count,
    output logic              nl_valid,
    input  logic              nl_ready,
    output logic [ADDR_W-1:0] nl_addr,
    output logic [LEN_W-1:0]  nl_bytes,
    output logic              nl_clean,
    output logic              nl_inval,
    output logic              done
);
    logic             start;
    logic             walk_idle;
    logic             walk_end;
    logic             fwd_busy;
    logic [PTR_W-1:0] first_line;
    logic [PTR_W-1:0] end_line;

    // Accept a request only when both the walk and the forward stage are free
    always_comb begin
        req_ready = walk_idle & ~fwd_busy;
        start     = req_valid & req_ready;
    end

    cmo_range_calc #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_range (
        .addr       (req_addr),
        .bytes_n    (req_bytes),
        .first_line (first_line),
        .end_line   (end_line)
    );

    cmo_walk_ctrl #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .LINE_BYTES (LINE_BYTES),
        .SETS       (SETS),
        .WAYS       (WAYS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .addr       (req_addr),
        .bytes_n    (req_bytes),
        .do_clean   (req_clean),
        .do_inval   (req_inval),
        .first_line (first_line),
        .end_line   (end_line),
        .lk_hit     (lk_hit),
        .lk_way     (lk_way),
        .lk_dirty   (lk_dirty),
        .idle       (walk_idle),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .upd_en     (upd_en),
        .upd_set    (upd_set),
        .upd_way    (upd_way),
        .upd_valid  (upd_valid),
        .upd_dirty  (upd_dirty),
        .wb_pulse   (wb_pulse),
        .walk_end   (walk_end),
        .org_addr   (nl_addr),
        .org_bytes  (nl_bytes),
        .org_clean  (nl_clean),
        .org_inval  (nl_inval)
    );

    cmo_fwd_stage #(
        .HAS_NEXT (HAS_NEXT)
    ) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .walk_end (walk_end),
        .nl_ready (nl_ready),
        .nl_valid (nl_valid),
        .done     (done),
        .busy     (fwd_busy)
    );

    // Count cleaned dirty lines; the counter wraps
    always_ff @(posedge clk) begin
        if (!rst_n)        wb_count <= '0;
        else if (wb_pulse) wb_count <= wb_count + WB_W'(1);
    end

    // R6: each writeback pulse advances the counter by one
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        wb_pulse |=> (wb_count == $past(wb_count) + WB_W'(1)));

    // R10: no request is taken while a walk is in progress
    a_r10_busy_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid || upd_en) |-> !req_ready);

    // R8: the forwarded payload does not move while it waits
    a_r8_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (nl_valid && !nl_ready) |=>
            ($stable(nl_addr) && $stable(nl_bytes) && $stable(nl_clean) && $stable(nl_inval)));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/cmo_range_walker_tb.sv
module cmo_range_walker_tb;
    localparam int AW = 8;
    localparam int LW = 6;
    localparam int LB = 8;
    localparam int NS = 4;
    localparam int NW = 2;
    localparam int WB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_bytes = '0;
    logic          req_clean = 1'b0;
    logic          req_inval = 1'b0;
    logic          nl_ready = 1'b0;

    logic          req_ready, lk_valid, lk_hit, lk_dirty, upd_en, upd_valid, upd_dirty;
    logic          wb_pulse, nl_valid, nl_clean, nl_inval, done;
    logic [AW-1:0] lk_addr, nl_addr;
    logic [LW-1:0] nl_bytes;
    logic [0:0]    lk_way, upd_way;
    logic [1:0]    upd_set;
    logic [WB-1:0] wb_count;

    logic          l_ready, l_lk_valid, l_upd_en, l_upd_valid, l_upd_dirty, l_wb_pulse;
    logic          l_nl_valid, l_nl_clean, l_nl_inval, l_done;
    logic [AW-1:0] l_lk_addr, l_nl_addr;
    logic [LW-1:0] l_nl_bytes;
    logic [0:0]    l_upd_way;
    logic [1:0]    l_upd_set;
    logic [WB-1:0] l_wb_count;

    cmo_range_walker #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB), .SETS(NS), .WAYS(NW),
                       .WB_W(WB), .HAS_NEXT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_clean(req_clean), .req_inval(req_inval),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_way(lk_way), .lk_dirty(lk_dirty),
        .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way), .upd_valid(upd_valid),
        .upd_dirty(upd_dirty), .wb_pulse(wb_pulse), .wb_count(wb_count),
        .nl_valid(nl_valid), .nl_ready(nl_ready), .nl_addr(nl_addr), .nl_bytes(nl_bytes),
        .nl_clean(nl_clean), .nl_inval(nl_inval), .done(done));

    // Second build without a next level; its tag store always misses
    cmo_range_walker #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB), .SETS(NS), .WAYS(NW),
                       .WB_W(WB), .HAS_NEXT(1'b0)) u_leaf (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(l_ready),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_clean(req_clean), .req_inval(req_inval),
        .lk_valid(l_lk_valid), .lk_addr(l_lk_addr), .lk_hit(1'b0), .lk_way(1'b0), .lk_dirty(1'b0),
        .upd_en(l_upd_en), .upd_set(l_upd_set), .upd_way(l_upd_way), .upd_valid(l_upd_valid),
        .upd_dirty(l_upd_dirty), .wb_pulse(l_wb_pulse), .wb_count(l_wb_count),
        .nl_valid(l_nl_valid), .nl_ready(1'b0), .nl_addr(l_nl_addr), .nl_bytes(l_nl_bytes),
        .nl_clean(l_nl_clean), .nl_inval(l_nl_inval), .done(l_done));

    // Tag store model: set = addr[4:3], tag = addr[7:5]
    bit       tv [NS][NW];
    bit       td [NS][NW];
    bit [2:0] tt [NS][NW];
    bit       fill_req = 1'b0;
    int       fill_seed = 0;

    always_comb begin
        lk_hit = 1'b0; lk_way = 1'b0; lk_dirty = 1'b0;
        for (int w = 0; w < NW; w++) begin
            if (tv[lk_addr[4:3]][w] && tt[lk_addr[4:3]][w] == lk_addr[7:5]) begin
                lk_hit = 1'b1; lk_way = 1'(w); lk_dirty = td[lk_addr[4:3]][w];
            end
        end
    end

    always @(posedge clk) begin
        if (fill_req) begin
            for (int s = 0; s < NS; s++) begin
                for (int w = 0; w < NW; w++) begin
                    int h;
                    h = s * 7 + w * 13 + fill_seed * 5;
                    tv[s][w] <= ((h >> 1) & 3) != 0;
                    td[s][w] <= ((h & 1) ^ ((h >> 2) & 1)) != 0;
                    tt[s][w] <= 3'(fill_seed + s + w * 4);
                end
            end
        end else if (upd_en) begin
            tv[upd_set][upd_way] <= upd_valid;
            td[upd_set][upd_way] <= upd_dirty;
        end
    end

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int exp_total = 0;
    bit leaf_bad = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // The miss-only leaf must never write or count
    always @(negedge clk) if (rst_n && (l_upd_en || l_wb_pulse || l_nl_valid)) leaf_bad = 1'b1;

    task automatic run_req(input int a, input int b, input bit cl, input bit iv, input int seed);
        bit ev [NS][NW];
        bit ed [NS][NW];
        int first, endv, nlines, ewb, d, nlk, ncnt, kdone, kleaf, exp_cur;
        bit seq_bad, pay_bad, busy_bad, tag_bad;
        // refill the tag store
        @(negedge clk); fill_seed = seed; fill_req = 1'b1;
        @(negedge clk); fill_req = 1'b0;
        first = (a / LB) * LB;
        endv = ((a + b + LB - 1) / LB) * LB;
        nlines = (endv - first) / LB;
        for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) begin
            ev[s][w] = tv[s][w]; ed[s][w] = td[s][w];
        end
        ewb = 0;
        for (int la = first; la < endv; la += LB) begin
            for (int w = 0; w < NW; w++) begin
                int s, t;
                s = (la >> 3) & 3; t = (la >> 5) & 7;
                if (ev[s][w] && int'(tt[s][w]) == t) begin
                    if (cl && ed[s][w]) begin ewb++; ed[s][w] = 1'b0; end
                    if (iv) begin ev[s][w] = 1'b0; ed[s][w] = 1'b0; end
                end
            end
        end
        d = (a + b) % 3;
        exp_total += ewb;
        req_addr = AW'(a); req_bytes = LW'(b); req_clean = cl; req_inval = iv;
        req_valid = 1'b1; nl_ready = 1'b0;
        nlk = 0; ncnt = 0; kdone = 0; kleaf = 0; exp_cur = first;
        seq_bad = 0; pay_bad = 0; busy_bad = !(req_ready && l_ready);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k < 80; k++) begin
            if (k > 1) @(negedge clk);
            if (lk_valid) begin
                if (int'(lk_addr) != (exp_cur & 255)) seq_bad = 1;
                exp_cur += LB; nlk++;
                // R10: offer a stray request during the walk
                req_valid = 1'b1; req_addr = AW'(a + 64); req_bytes = LW'(9);
            end else begin
                req_valid = 1'b0;
            end
            if (nl_valid) begin
                if (int'(nl_addr) != a || int'(nl_bytes) != b || nl_clean != cl || nl_inval != iv)
                    pay_bad = 1;
                ncnt++;
                nl_ready = (ncnt > d);
            end else begin
                nl_ready = 1'b0;
            end
            if (done && kdone == 0) kdone = k;
            if (l_done && kleaf == 0) kleaf = k;
            if (!done && kdone == 0 && req_ready) busy_bad = 1;
            if (kdone != 0 && kleaf != 0) break;
        end
        req_valid = 1'b0; nl_ready = 1'b0;
        tag_bad = 0;
        for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++)
            if (tv[s][w] != ev[s][w] || td[s][w] != ed[s][w]) tag_bad = 1;
        chk(nlk == nlines, "R3 lookup count", nlk, nlines);
        chk(!seq_bad, "R2 lookup address sequence", int'(seq_bad), 0);
        chk(!tag_bad, "R5/R6/R7 tag state after walk", int'(tag_bad), 0);
        chk(int'(wb_count) == (exp_total & 16'hFFFF), "R6 writeback count", int'(wb_count), exp_total);
        chk(kdone == 2 * nlines + 2 + d, "R4/R8 done latency", kdone, 2 * nlines + 2 + d);
        chk(!pay_bad && ncnt == d + 1, "R8 forwarded request", ncnt, d + 1);
        chk(kleaf == 2 * nlines + 1, "R9 leaf done latency", kleaf, 2 * nlines + 1);
        chk(!busy_bad, "R10 ready low while busy", int'(busy_bad), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready && l_ready, "R1 ready after reset", int'(req_ready), 1);
        chk(!done && !lk_valid && !upd_en && !wb_pulse && !nl_valid, "R1 idle outputs", int'(done), 0);
        chk(wb_count == '0, "R1 counter cleared", int'(wb_count), 0);
        begin
            int seed;
            seed = 0;
            for (int fl = 0; fl < 4; fl++)
                for (int a = 0; a < 24; a++)
                    for (int b = 0; b < 20; b++) begin
                        run_req(a, b, fl[0], fl[1], seed);
                        seed++;
                    end
            // near the top of the address space
            for (int fl = 0; fl < 4; fl++) begin
                run_req(240, 15, fl[0], fl[1], seed + 1);
                run_req(255, 0, fl[0], fl[1], seed + 2);
                run_req(192, 63, fl[0], fl[1], seed + 3);
                run_req(249, 6, fl[0], fl[1], seed + 4);
            end
        end
        chk(!leaf_bad, "R5/R9 leaf never writes or forwards", int'(leaf_bad), 0);
        chk(l_wb_count == '0, "R5 misses count nothing", int'(l_wb_count), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule